// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit

This block takes one single-precision binary floating-point word and returns it rounded to a whole number. The result is still a floating-point word. A 2-bit selector picks how the rounding is done: ties-to-even nearest, truncation toward zero, or a directed step toward plus or minus infinity. The result is registered once. A valid strobe comes out one cycle after the strobe that went in, and a flag reports when the result is not equal to the operand.

The word has three fields. Bit 31 is the sign, bits 30:23 hold an exponent biased by 127, and bits 22:0 hold the fraction. A normal number has a hidden leading 1. Operands that have no fractional bits are passed through unchanged: large values, infinities and zeros. A NaN leaves as a quiet NaN. Any value whose magnitude is below one collapses to a signed zero or to a signed 1.0. The sign of the operand is kept in every result, including zero results.

Top module: `fp_round_integral`

## Requirements
- R1: `in_mode` selects the rounding rule: 0 = nearest with ties to even, 1 = toward zero, 2 = toward plus infinity, 3 = toward minus infinity. The word layout is sign in bit 31, biased exponent (bias 127) in bits 30:23 and fraction in bits 22:0.
- R2: In mode 0, a value exactly halfway between two integers goes to the even one. For example, 2.5 gives 2.0 and 3.5 gives 4.0. Any other value goes to the closer integer.
- R3: In mode 1, the fractional part is dropped, so the magnitude never grows. For example, 2.3 gives 2.0 and -2.3 gives -2.0.
- R4: Mode 2 moves any non-integral value up to the next integer, and mode 3 moves it down. For example, -2.3 gives -2.0 in mode 2 and -3.0 in mode 3.
- R5: An operand with an exponent field of 150 to 254 is already integral. It comes out bit-for-bit unchanged with the inexact flag low.
- R6: Infinity (exponent field 255, fraction 0) comes out unchanged with the inexact flag low.
- R7: A NaN (exponent field 255, fraction not zero) comes out as the same word with fraction bit 22 forced to 1, and the inexact flag is low.
- R8: For a magnitude below 1, including denormals, the result is a zero or a 1.0 that carries the operand's sign. Mode 0 gives 1.0 only when the magnitude is strictly above 0.5, so exactly 0.5 gives 0. Modes 2 and 3 give 1.0 only for a nonzero operand on the positive side or the negative side respectively.
- R9: For a non-NaN operand, `out_inexact` is 1 exactly when the result word differs from the operand word. A zero operand therefore gives a zero result with the flag low.
- R10: `out_valid` is high exactly one cycle after each cycle in which `in_valid` is high. A synchronous active-high reset clears `out_valid`, `out_word` and `out_inexact` to 0.
- R11: When rounding carries into the next power of two, the exponent goes up by one and the fraction becomes zero. For example, 1.5 gives 2.0 and 7.5 gives 8.0 in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_word | input | 32 | Operand word |
| in_mode | input | 2 | Rounding rule selector |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_word | output | 32 | Rounded result word |
| out_inexact | output | 1 | High when the result differs from the operand |

## Verification
Some properties are checked on every clock by assertions:
- the strobe timing;
- sign preservation;
- pass-through of infinities and already-integral values;
- the quiet-NaN form;
- the link between the inexact flag and a change in the word.

The actual rounding choices can only be shown by the bench's scenarios. These include ties going to even, directed steps on each side of zero, the 0.5 boundary, denormals, and carries into a new binade. In each case the registered result is compared with an independent integer model.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int MANT_W  = FRAC_W + 1;
    localparam int SH_W    = $clog2(MANT_W + 1);
    localparam int BIAS    = 127;
    localparam int INT_EXP = BIAS + FRAC_W;

    localparam logic [EXP_W-1:0] EXP_ONES = '1;

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'd0,
        RND_TRUNC     = 2'd1,
        RND_POS       = 2'd2,
        RND_NEG       = 2'd3
    } rnd_mode_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUBUNIT,
        CLS_FRACTIONAL,
        CLS_INTEGRAL,
        CLS_INF,
        CLS_NAN
    } fp_class_e;

    function automatic logic round_up(
        input rnd_mode_e mode,
        input logic      sign,
        input logic      int_lsb,
        input logic      half_bit,
        input logic      rest_bits
    );
        logic any_frac;
        any_frac = half_bit | rest_bits;
        case (mode)
            RND_NEAR_EVEN: return half_bit & (rest_bits | int_lsb);
            RND_TRUNC:     return 1'b0;
            RND_POS:       return ~sign & any_frac;
            default:       return sign & any_frac;
        endcase
    endfunction

endpackage

// File: rtl/fpr_classify.sv
module fpr_classify
    import fpr_pkg::*;
(
    input  fp_word_t  word,
    output fp_class_e cls
);
    logic frac_nz;
    assign frac_nz = |word.frac;

    always_comb begin
        if (word.expo == EXP_ONES)
            cls = frac_nz ? CLS_NAN : CLS_INF;
        else if (word.expo >= EXP_W'(INT_EXP))
            cls = CLS_INTEGRAL;
        else if (word.expo >= EXP_W'(BIAS))
            cls = CLS_FRACTIONAL;
        else if (word.expo == '0 && !frac_nz)
            cls = CLS_ZERO;
        else
            cls = CLS_SUBUNIT;
    end
endmodule

// File: rtl/fpr_frac_split.sv
module fpr_frac_split
    import fpr_pkg::*;
(
    input  fp_word_t        word,
    input  logic            active,
    output logic [MANT_W:0] kept,
    output logic [MANT_W:0] unit,
    output logic            int_lsb,
    output logic            half_bit,
    output logic            rest_bits
);
    logic [MANT_W:0] mant;
    logic [MANT_W:0] mask;
    logic [SH_W-1:0] sh;

    assign mant = {1'b0, 1'b1, word.frac};

    always_comb begin
        if (active)
            sh = SH_W'(EXP_W'(INT_EXP) - word.expo);
        else
            sh = SH_W'(1);
        mask = ({{MANT_W{1'b0}}, 1'b1} << sh) - {{MANT_W{1'b0}}, 1'b1};
    end

    assign unit      = mask + {{MANT_W{1'b0}}, 1'b1};
    assign kept      = mant & ~mask;
    assign int_lsb   = |(mant & unit);
    assign half_bit  = |(mant & (mask ^ (mask >> 1)));
    assign rest_bits = |(mant & (mask >> 1));
endmodule

// File: rtl/fpr_round_core.sv
module fpr_round_core
    import fpr_pkg::*;
(
    input  fp_word_t  word,
    input  rnd_mode_e mode,
    input  fp_class_e cls,
    output fp_word_t  result,
    output logic      inexact
);
    logic [MANT_W:0] kept;
    logic [MANT_W:0] unit;
    logic [MANT_W:0] sum;
    logic            int_lsb;
    logic            half_bit;
    logic            rest_bits;
    logic            frac_inc;
    logic            sub_inc;
    logic            sub_half;
    logic            sub_rest;

    fpr_frac_split u_split (
        .word      (word),
        .active    (cls == CLS_FRACTIONAL),
        .kept      (kept),
        .unit      (unit),
        .int_lsb   (int_lsb),
        .half_bit  (half_bit),
        .rest_bits (rest_bits)
    );

    assign frac_inc = round_up(mode, word.sign, int_lsb, half_bit, rest_bits);
    assign sum      = kept + (frac_inc ? unit : '0);

    assign sub_half = (word.expo == EXP_W'(BIAS - 1));
    assign sub_rest = sub_half ? (|word.frac) : 1'b1;
    assign sub_inc  = round_up(mode, word.sign, 1'b0, sub_half, sub_rest);

    always_comb begin
        result  = word;
        inexact = 1'b0;
        case (cls)
            CLS_NAN: begin
                result.frac[FRAC_W-1] = 1'b1;
            end
            CLS_SUBUNIT: begin
                result.expo = sub_inc ? EXP_W'(BIAS) : '0;
                result.frac = '0;
                inexact     = 1'b1;
            end
            CLS_FRACTIONAL: begin
                if (sum[MANT_W]) begin
                    result.expo = word.expo + EXP_W'(1);
                    result.frac = '0;
                end else begin
                    result.frac = sum[FRAC_W-1:0];
                end
                inexact = half_bit | rest_bits;
            end
            default: begin
                result  = word;
                inexact = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fp_round_integral.sv
module fp_round_integral
    import fpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              out_inexact
);
    fp_word_t  op;
    fp_word_t  res;
    fp_class_e cls;
    logic      res_inexact;

    assign op = fp_word_t'(in_word);

    fpr_classify u_classify (
        .word (op),
        .cls  (cls)
    );

    fpr_round_core u_core (
        .word    (op),
        .mode    (rnd_mode_e'(in_mode)),
        .cls     (cls),
        .result  (res),
        .inexact (res_inexact)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_word    <= '0;
            out_inexact <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word    <= res;
                out_inexact <= res_inexact;
            end
        end
    end

    logic in_is_nan;
    logic in_is_inf;
    logic in_is_big;
    assign in_is_nan = (in_word[30:23] == EXP_ONES) && (in_word[22:0] != '0);
    assign in_is_inf = (in_word[30:23] == EXP_ONES) && (in_word[22:0] == '0);
    assign in_is_big = (in_word[30:23] != EXP_ONES) && (in_word[30:23] >= EXP_W'(INT_EXP));

    a_r10_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r10_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r6_inf_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_is_inf) |=> (out_word == $past(in_word)) && !out_inexact);
    a_r5_big_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_is_big) |=> (out_word == $past(in_word)) && !out_inexact);
    a_r7_quiet_nan: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_is_nan) |=> out_word[30:22] == '1 && !out_inexact);
    a_r8_sign_kept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_is_nan) |=> out_word[31] == $past(in_word[31]));
    a_r9_inexact_diff: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_is_nan) |=> out_inexact == (out_word != $past(in_word)));
endmodule

// File: tb/test_fp_round_integral.sv
module test_fp_round_integral;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_inexact;

    int checks = 0;
    int failures = 0;
    logic prev_v = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] w;
        logic        ix;
        string       tag;
    } exp_t;
    exp_t q_exp[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_round_integral i_fp_round_integral (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_word     (in_word),
        .in_mode     (in_mode),
        .out_valid   (out_valid),
        .out_word    (out_word),
        .out_inexact (out_inexact)
    );

    // Integer model: split off the integer quotient, round, re-encode.
    function automatic void ref_round(input logic [31:0] w, input logic [1:0] md,
                                      output logic [31:0] r, output logic ix);
        logic s;
        int ef;
        longint fr, m, den, q, rm, tmp;
        int f, p;
        logic inc, nz;
        s  = w[31];
        ef = int'(w[30:23]);
        fr = longint'(w[22:0]);
        r  = w;
        ix = 1'b0;
        inc = 1'b0;
        if (ef == 255) begin
            if (fr != 0) r = w | 32'h0040_0000;
        end else if (ef >= 150) begin
            r = w;
        end else if (ef < 127) begin
            nz = (ef != 0) || (fr != 0);
            case (md)
                2'd0: inc = (ef == 126) && (fr != 0);
                2'd1: inc = 1'b0;
                2'd2: inc = !s && nz;
                default: inc = s && nz;
            endcase
            r = inc ? {s, 8'd127, 23'd0} : {s, 31'd0};
            ix = (r != w);
        end else begin
            m   = (longint'(1) << 23) | fr;
            f   = 150 - ef;
            den = longint'(1) << f;
            q   = m / den;
            rm  = m % den;
            case (md)
                2'd0: inc = (2*rm > den) || ((2*rm == den) && (q % 2 == 1));
                2'd1: inc = 1'b0;
                2'd2: inc = !s && (rm != 0);
                default: inc = s && (rm != 0);
            endcase
            q = q + longint'(inc);
            p = 0;
            for (int i = 0; i < 40; i++) if (q[i]) p = i;
            tmp = q << (23 - p);
            r[31]    = s;
            r[30:23] = 8'(127 + p);
            r[22:0]  = tmp[22:0];
            ix = (r != w);
        end
    endfunction

    task automatic fail_msg(input string tag, input logic [31:0] aw, input logic ai,
                            input logic [31:0] ew, input logic ei);
        failures++;
        $display("FAIL %s: actual word=%h inexact=%b expected word=%h inexact=%b",
                 tag, aw, ai, ew, ei);
    endtask

    task automatic check_out();
        exp_t e;
        checks++;
        if (out_valid !== prev_v) begin
            failures++;
            $display("FAIL R10: out_valid actual=%b expected=%b", out_valid, prev_v);
        end
        if (prev_v) begin
            e = q_exp.pop_front();
            checks++;
            if (out_word !== e.w || out_inexact !== e.ix)
                fail_msg(e.tag, out_word, out_inexact, e.w, e.ix);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] w, input logic [1:0] md,
                        input string tag);
        exp_t e;
        @(negedge clk);
        check_out();
        in_valid = v;
        in_word  = w;
        in_mode  = md;
        if (v) begin
            ref_round(w, md, e.w, e.ix);
            e.tag = tag;
            q_exp.push_back(e);
        end
        prev_v = v;
    endtask

    task automatic all_modes(input logic [31:0] w, input string tag);
        for (int k = 0; k < 4; k++) step(1'b1, w, 2'(k), tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_word !== 32'h0 || out_inexact !== 1'b0) begin
            failures++;
            $display("FAIL R10: reset state actual=%b/%h/%b expected=0/00000000/0",
                     out_valid, out_word, out_inexact);
        end
        rst = 1'b0;

        // R2 ties to even, R11 carry into next binade
        step(1, 32'h4020_0000, 0, "R2 2.5 nearest");
        step(1, 32'h4060_0000, 0, "R2 3.5 nearest");
        step(1, 32'hC020_0000, 0, "R2 -2.5 nearest");
        step(1, 32'h3FC0_0000, 0, "R11 1.5 nearest");
        step(1, 32'h40F0_0000, 0, "R11 7.5 nearest");
        step(1, 32'h4AFF_FFFF, 0, "R11 top of fractional range");
        // R3 truncation, R4 directed
        step(1, 32'h4013_3333, 1, "R3 2.3 toward zero");
        step(1, 32'hC013_3333, 1, "R3 -2.3 toward zero");
        step(1, 32'h4013_3333, 2, "R4 2.3 up");
        step(1, 32'hC013_3333, 2, "R4 -2.3 up");
        step(1, 32'hC013_3333, 3, "R4 -2.3 down");
        step(1, 32'h4013_3333, 3, "R4 2.3 down");
        // R1 mode selector on one operand
        all_modes(32'h4016_6666, "R1 2.35 all modes");
        // R8 sub-unit values and denormals
        step(1, 32'hBE99_999A, 0, "R8 -0.3 nearest gives -0");
        step(1, 32'h3F00_0000, 0, "R8 0.5 nearest gives 0");
        step(1, 32'h3F00_0001, 0, "R8 just above 0.5");
        all_modes(32'h0000_0001, "R8 positive denormal");
        all_modes(32'h8000_0001, "R8 negative denormal");
        all_modes(32'hBF40_0000, "R8 -0.75");
        // R9 zeros and exact integers
        all_modes(32'h0000_0000, "R9 +0");
        all_modes(32'h8000_0000, "R9 -0");
        all_modes(32'h4040_0000, "R9 exact 3.0");
        // R5 large, R6 infinity, R7 NaN
        all_modes(32'h4B00_0001, "R5 exponent 150");
        all_modes(32'hFF7F_FFFF, "R5 largest negative finite");
        all_modes(32'h7F80_0000, "R6 +inf");
        all_modes(32'hFF80_0000, "R6 -inf");
        all_modes(32'h7FA0_0000, "R7 signalling NaN");
        all_modes(32'hFFC0_0001, "R7 quiet NaN");
        // R10 gaps in the strobe
        step(0, 32'h3FC0_0000, 0, "R10 idle");
        step(1, 32'h3FC0_0000, 2, "R10 after idle");
        step(0, 32'h0, 0, "R10 idle");
        step(0, 32'h0, 0, "R10 idle");

        for (int n = 0; n < 3000; n++) begin
            logic [31:0] w;
            w = $urandom;
            if (n % 3 != 0) w[30:23] = 8'(118 + ($urandom % 36));
            step(($urandom % 5) != 0, w, 2'($urandom), "R9 mixed operand");
        end
        step(0, 32'h0, 0, "R10 drain");
        step(0, 32'h0, 0, "R10 drain");
        finish_run();
    end
endmodule